// File: doc/BRIEF.md
# Buffered-compare PWM timer

This block generates pulse-width modulated waveforms from a free-running 8-bit up-counter. The counter climbs from zero to a programmable ceiling and then returns to zero, so one PWM period lasts (ceiling + 1) timer clocks. Two compare channels watch the counter, and each channel drives a primary PWM pin plus a companion pin. Each pin has its own output-enable.

Software reaches the block through a small synchronous register port. A compare value written by software first lands in a holding register. It moves into the channel's working register only in the cycle where the counter wraps, and both channels move together. A pending change therefore never cuts a pulse short or stretches it. A read of a compare address returns the held value, which is the last one written.

A 2-bit mode per channel selects one of four behaviours: pins released, a complementary pair, a plain output or an inverted output. Compare values of zero and of the ceiling force fixed levels. An overflow flag and one compare flag per channel record counter events. Each flag is cleared by writing a one to it and raises an interrupt request when its enable bit is set.

Top module: `cmpwm_timer`

## Requirements
- R1: The counter advances by one each clock, and in the cycle after it equals or exceeds the ceiling (address 1, reset value 0xFF) it reads zero, giving a period of ceiling + 1 clocks. The count can be read at address 6.
- R2: A write to address 2 (channel 0) or 3 (channel 1) stores the compare value in a holding register. A read of that address returns the most recently written value, even before that value takes effect.
- R3: Holding values are copied into both channels' working compare registers on the clock edge at which the counter wraps to zero. Until that edge, the outputs follow the previous working value.
- R4: In mode 2 (mode register address 0: bits 1:0 for channel 0, bits 3:2 for channel 1), when the working compare value C satisfies 0 < C < ceiling, the output is high while count < C and low from count = C up to the wrap.
- R5: Mode 3 drives the output with the exact complement of the mode 2 waveform.
- R6: A working compare value of zero gives a non-inverted level of low for the whole period. A value equal to or above the ceiling gives a non-inverted level of high. Mode 3 inverts both of these levels.
- R7: Mode 1 drives the output with the mode 2 waveform and drives the companion with its complement, with both output-enables asserted.
- R8: Mode 0 holds both pins of the channel low with both output-enables low. Modes 2 and 3 hold the companion pin low with its enable low.
- R9: The flag register (address 4) has bit 0 for overflow, set on each wrap, and bit 1+n, set when the count equals channel n's working compare value.
- R10: Writing a one to a flag bit clears only that bit. If the flag's set event happens in the same cycle, the flag stays set.
- R11: Each interrupt request output is high exactly while its flag and its matching enable bit (address 5, same bit positions as the flag register) are both set.
- R12: While reset is asserted, the flag, enable, mode and compare registers read zero, the ceiling reads 0xFF, the count reads zero, and all pins, enables and interrupt requests are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe, sampled at the rising edge |
| addr | input | 3 | Register address for writes and reads |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| pwm_out | output | 2 | Primary PWM pin per channel |
| pwm_out_n | output | 2 | Companion pin per channel |
| pwm_oe | output | 2 | Output-enable of the primary pin |
| pwm_oe_n | output | 2 | Output-enable of the companion pin |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_cmp | output | 2 | Compare-match interrupt request per channel |

## Verification
The assertions take the register port as synchronous: `wr_en`, `addr` and `wdata` are known and settled at every rising edge, and a ceiling write may land at any count, including below the current count. The bench changes inputs only on falling edges and uses only the seven mapped addresses. Before it expects a new compare value to show on a pin, it waits for the count to reach the ceiling after the write, so every sampled waveform comes from a working value latched at a known wrap. It keeps the ceiling at 20 or above, so each period is long enough for a wrap edge to be placed deliberately, for instance to make a flag clear coincide with its set event.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

  typedef enum logic [1:0] {
    PM_OFF    = 2'd0,
    PM_PAIR   = 2'd1,
    PM_DIRECT = 2'd2,
    PM_INVERT = 2'd3
  } pmode_e;

  localparam int unsigned AW = 3;

  localparam logic [AW-1:0] ADR_MODE  = 3'd0;
  localparam logic [AW-1:0] ADR_TOP   = 3'd1;
  localparam logic [AW-1:0] ADR_CMP0  = 3'd2;
  localparam logic [AW-1:0] ADR_FLAG  = 3'd4;
  localparam logic [AW-1:0] ADR_IRQEN = 3'd5;
  localparam logic [AW-1:0] ADR_CNT   = 3'd6;

endpackage

// File: rtl/pwmt_counter.sv
module pwmt_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] top,
  output logic [W-1:0] cnt,
  output logic         wrap
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  // count runs every timer clock; the enable is kept explicit
  always_comb begin
    cnt_en = 1'b1;
    wrap   = (cnt_q >= top);
    cnt_d  = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/pwmt_regs.sv
module pwmt_regs
  import pwmt_pkg::*;
#(
  parameter int unsigned W   = 8,
  parameter int unsigned NCH = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          addr,
  input  logic [W-1:0]           wdata,
  input  logic [NCH:0]           set_evt,
  output logic [2*NCH-1:0]       mode_q,
  output logic [W-1:0]           top_q,
  output logic [NCH-1:0][W-1:0]  shd_q,
  output logic [NCH:0]           flag_q,
  output logic [NCH:0]           irqen_q
);

  localparam int unsigned MW = 2 * NCH;
  localparam int unsigned FW = NCH + 1;

  logic                  mode_we, top_we, flag_we, irqen_we;
  logic [NCH-1:0]        shd_we;
  logic [MW-1:0]         mode_d;
  logic [W-1:0]          top_d;
  logic [NCH-1:0][W-1:0] shd_d;
  logic [FW-1:0]         flag_d, flag_clr;
  logic [FW-1:0]         irqen_d;

  always_comb begin
    mode_we  = wr_en && (addr == ADR_MODE);
    top_we   = wr_en && (addr == ADR_TOP);
    flag_we  = wr_en && (addr == ADR_FLAG);
    irqen_we = wr_en && (addr == ADR_IRQEN);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_shd_we
    localparam logic [AW-1:0] CADR = ADR_CMP0 + AW'(c);
    assign shd_we[c] = wr_en && (addr == CADR);
  end

  always_comb begin
    mode_d   = mode_we  ? wdata[MW-1:0] : mode_q;
    top_d    = top_we   ? wdata         : top_q;
    irqen_d  = irqen_we ? wdata[FW-1:0] : irqen_q;
    flag_clr = flag_we  ? wdata[FW-1:0] : '0;
    // a set event in the same cycle outranks the clear
    flag_d   = (flag_q & ~flag_clr) | set_evt;
    shd_d    = shd_q;
    for (int c = 0; c < NCH; c++) begin
      if (shd_we[c]) begin
        shd_d[c] = wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      top_q   <= '1;
      shd_q   <= '0;
      flag_q  <= '0;
      irqen_q <= '0;
    end else begin
      mode_q  <= mode_d;
      top_q   <= top_d;
      shd_q   <= shd_d;
      flag_q  <= flag_d;
      irqen_q <= irqen_d;
    end
  end

endmodule

// File: rtl/pwmt_channel.sv
module pwmt_channel
  import pwmt_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wrap,
  input  logic [W-1:0] shadow,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] top,
  input  pmode_e       mode,
  output logic [W-1:0] act,
  output logic         hit,
  output logic         out,
  output logic         out_n,
  output logic         oe,
  output logic         oe_n
);

  logic [W-1:0] act_q;
  logic [W-1:0] act_d;
  logic         lvl;

  // working compare only loads at the counter wrap
  always_comb begin
    act_d = wrap ? shadow : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
    end else begin
      act_q <= act_d;
    end
  end

  always_comb begin
    if (act_q == '0) begin
      lvl = 1'b0;
    end else if (act_q >= top) begin
      lvl = 1'b1;
    end else begin
      lvl = (cnt < act_q);
    end
    hit = (cnt == act_q);
  end

  always_comb begin
    out   = 1'b0;
    out_n = 1'b0;
    oe    = 1'b0;
    oe_n  = 1'b0;
    case (mode)
      PM_PAIR: begin
        out   = lvl;
        out_n = ~lvl;
        oe    = 1'b1;
        oe_n  = 1'b1;
      end
      PM_DIRECT: begin
        out = lvl;
        oe  = 1'b1;
      end
      PM_INVERT: begin
        out = ~lvl;
        oe  = 1'b1;
      end
      default: begin
        out = 1'b0;
      end
    endcase
  end

  assign act = act_q;

endmodule

// File: rtl/cmpwm_timer.sv
module cmpwm_timer
  import pwmt_pkg::*;
#(
  parameter int unsigned W   = 8,
  parameter int unsigned NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [2:0]     addr,
  input  logic [W-1:0]   wdata,
  output logic [W-1:0]   rdata,
  output logic [NCH-1:0] pwm_out,
  output logic [NCH-1:0] pwm_out_n,
  output logic [NCH-1:0] pwm_oe,
  output logic [NCH-1:0] pwm_oe_n,
  output logic           irq_ovf,
  output logic [NCH-1:0] irq_cmp
);

  localparam int unsigned MW = 2 * NCH;
  localparam int unsigned FW = NCH + 1;

  logic [1:0]            rs_q;
  logic                  rst_ns;
  logic [W-1:0]          cnt_w;
  logic                  wrap_w;
  logic [W-1:0]          top_w;
  logic [MW-1:0]         mode_w;
  logic [NCH-1:0][W-1:0] shd_w;
  logic [NCH-1:0][W-1:0] act_w;
  logic [NCH-1:0]        hit_w;
  logic [FW-1:0]         set_w;
  logic [FW-1:0]         flag_w;
  logic [FW-1:0]         irqen_w;
  logic [FW-1:0]         irq_w;

  // reset asserts at once and leaves on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_ns = rs_q[1];

  pwmt_counter #(.W(W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_ns),
    .top  (top_w),
    .cnt  (cnt_w),
    .wrap (wrap_w)
  );

  pwmt_regs #(.W(W), .NCH(NCH)) u_regs (
    .clk    (clk),
    .rst_n  (rst_ns),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .set_evt(set_w),
    .mode_q (mode_w),
    .top_q  (top_w),
    .shd_q  (shd_w),
    .flag_q (flag_w),
    .irqen_q(irqen_w)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwmt_channel #(.W(W)) u_ch (
      .clk   (clk),
      .rst_n (rst_ns),
      .wrap  (wrap_w),
      .shadow(shd_w[c]),
      .cnt   (cnt_w),
      .top   (top_w),
      .mode  (pmode_e'(mode_w[2*c +: 2])),
      .act   (act_w[c]),
      .hit   (hit_w[c]),
      .out   (pwm_out[c]),
      .out_n (pwm_out_n[c]),
      .oe    (pwm_oe[c]),
      .oe_n  (pwm_oe_n[c])
    );
  end

  always_comb begin
    set_w   = {hit_w, wrap_w};
    irq_w   = flag_w & irqen_w;
    irq_ovf = irq_w[0];
    irq_cmp = irq_w[FW-1:1];
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADR_MODE:  rdata = {{(W-MW){1'b0}}, mode_w};
      ADR_TOP:   rdata = top_w;
      ADR_FLAG:  rdata = {{(W-FW){1'b0}}, flag_w};
      ADR_IRQEN: rdata = {{(W-FW){1'b0}}, irqen_w};
      ADR_CNT:   rdata = cnt_w;
      default:   rdata = '0;
    endcase
    for (int c = 0; c < NCH; c++) begin
      if (addr == ADR_CMP0 + AW'(c)) begin
        rdata = shd_w[c];
      end
    end
  end

endmodule

// File: rtl/pwmt_chk.sv
module pwmt_chk #(
  parameter int unsigned W   = 8,
  parameter int unsigned NCH = 2
) (
  input logic                  clk,
  input logic                  rst_ns,
  input logic [W-1:0]          cnt,
  input logic [W-1:0]          top,
  input logic                  wrap,
  input logic [NCH-1:0][W-1:0] act,
  input logic [NCH-1:0][W-1:0] shd,
  input logic [2*NCH-1:0]      mode,
  input logic [NCH:0]          flag,
  input logic [NCH:0]          set_evt,
  input logic [NCH-1:0]        out,
  input logic [NCH-1:0]        out_n,
  input logic [NCH-1:0]        oe,
  input logic [NCH-1:0]        oe_n
);

  // R1
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (cnt >= top) |=> (cnt == '0));

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (cnt < top) |=> (cnt == W'($past(cnt) + 1'b1)));

  // R3
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !wrap |=> $stable(act));

  // R3
  act_load_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    wrap |=> (act == $past(shd)));

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (|set_evt) |=> ((flag & $past(set_evt)) == $past(set_evt)));

  for (genvar c = 0; c < NCH; c++) begin : g_pin
    // R8
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ns)
      (mode[2*c +: 2] == 2'b00) |-> (!oe[c] && !oe_n[c] && !out[c] && !out_n[c]));

    // R8
    single_comp_chk: assert property (@(posedge clk) disable iff (!rst_ns)
      mode[2*c+1] |-> (!oe_n[c] && !out_n[c] && oe[c]));

    // R7
    pair_comp_chk: assert property (@(posedge clk) disable iff (!rst_ns)
      (mode[2*c +: 2] == 2'b01) |-> ((out_n[c] != out[c]) && oe[c] && oe_n[c]));
  end

endmodule

bind cmpwm_timer pwmt_chk #(.W(W), .NCH(NCH)) u_chk (
  .clk    (clk),
  .rst_ns (rst_ns),
  .cnt    (cnt_w),
  .top    (top_w),
  .wrap   (wrap_w),
  .act    (act_w),
  .shd    (shd_w),
  .mode   (mode_w),
  .flag   (flag_w),
  .set_evt(set_w),
  .out    (pwm_out),
  .out_n  (pwm_out_n),
  .oe     (pwm_oe),
  .oe_n   (pwm_oe_n)
);

// File: tb/sim_cmpwm_timer.sv
`timescale 1ns/1ps
module sim_cmpwm_timer;

  localparam logic [2:0] A_MODE = 3'd0;
  localparam logic [2:0] A_TOP  = 3'd1;
  localparam logic [2:0] A_CMP0 = 3'd2;
  localparam logic [2:0] A_CMP1 = 3'd3;
  localparam logic [2:0] A_FLAG = 3'd4;
  localparam logic [2:0] A_IEN  = 3'd5;
  localparam logic [2:0] A_CNT  = 3'd6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic [1:0] pwm_out, pwm_out_n, pwm_oe, pwm_oe_n, irq_cmp;
  logic       irq_ovf;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cmpwm_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pwm_out(pwm_out), .pwm_out_n(pwm_out_n),
    .pwm_oe(pwm_oe), .pwm_oe_n(pwm_oe_n), .irq_ovf(irq_ovf), .irq_cmp(irq_cmp)
  );

  typedef struct packed {
    logic [1:0] mode;
    logic [7:0] top;
    logic [7:0] cmp;
    logic [7:0] at;
    logic       o;
    logic       on;
    logic       oe;
    logic       oen;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{2'd2, 8'd99, 8'd40, 8'd10, 1'b1, 1'b0, 1'b1, 1'b0},
    '{2'd2, 8'd99, 8'd40, 8'd40, 1'b0, 1'b0, 1'b1, 1'b0},
    '{2'd2, 8'd99, 8'd40, 8'd99, 1'b0, 1'b0, 1'b1, 1'b0},
    '{2'd3, 8'd99, 8'd40, 8'd10, 1'b0, 1'b0, 1'b1, 1'b0},
    '{2'd3, 8'd99, 8'd40, 8'd60, 1'b1, 1'b0, 1'b1, 1'b0},
    '{2'd1, 8'd99, 8'd40, 8'd10, 1'b1, 1'b0, 1'b1, 1'b1},
    '{2'd1, 8'd99, 8'd40, 8'd50, 1'b0, 1'b1, 1'b1, 1'b1},
    '{2'd1, 8'd99, 8'd0,  8'd0,  1'b0, 1'b1, 1'b1, 1'b1},
    '{2'd1, 8'd99, 8'd99, 8'd99, 1'b1, 1'b0, 1'b1, 1'b1},
    '{2'd2, 8'd99, 8'd0,  8'd5,  1'b0, 1'b0, 1'b1, 1'b0},
    '{2'd2, 8'd99, 8'd99, 8'd99, 1'b1, 1'b0, 1'b1, 1'b0},
    '{2'd3, 8'd99, 8'd0,  8'd5,  1'b1, 1'b0, 1'b1, 1'b0},
    '{2'd3, 8'd99, 8'd99, 8'd50, 1'b0, 1'b0, 1'b1, 1'b0},
    '{2'd0, 8'd99, 8'd40, 8'd10, 1'b0, 1'b0, 1'b0, 1'b0},
    '{2'd2, 8'd20, 8'd5,  8'd4,  1'b1, 1'b0, 1'b1, 1'b0},
    '{2'd2, 8'd20, 8'd5,  8'd5,  1'b0, 1'b0, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_cnt(input logic [7:0] v);
    forever begin
      @(negedge clk);
      addr = A_CNT;
      #1;
      if (rdata == v) break;
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d;
    string tag;
    int n;

    // R12 reset state
    repeat (3) @(negedge clk);
    rd(A_TOP, d);  chk("R12 ceiling reset", d, 8'hFF);
    rd(A_CMP0, d); chk("R12 cmp0 reset", d, 8'h00);
    rd(A_FLAG, d); chk("R12 flags reset", d, 8'h00);
    rd(A_MODE, d); chk("R12 mode reset", d, 8'h00);
    rd(A_CNT, d);  chk("R12 count reset", d, 8'h00);
    chk("R12 pins reset", {pwm_out, pwm_out_n, pwm_oe, pwm_oe_n}, 8'h00);
    chk("R12 irq reset", {irq_ovf, irq_cmp}, 3'b000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table walk on channel 0
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].mode == 2'd0) tag = "R8";
      else if (VEC[i].cmp == 8'd0 || VEC[i].cmp >= VEC[i].top) tag = "R6";
      else if (VEC[i].mode == 2'd1) tag = "R7";
      else if (VEC[i].mode == 2'd3) tag = "R5";
      else tag = "R4";
      wr(A_TOP, VEC[i].top);
      wr(A_MODE, {6'd0, VEC[i].mode});
      wr(A_CMP0, VEC[i].cmp);
      wait_cnt(VEC[i].top);
      wait_cnt(VEC[i].at);
      chk({tag, " out"},   pwm_out[0],   VEC[i].o);
      chk({tag, " out_n"}, pwm_out_n[0], VEC[i].on);
      chk({tag, " oe"},    pwm_oe[0],    VEC[i].oe);
      chk({tag, " oe_n"},  pwm_oe_n[0],  VEC[i].oen);
    end

    // R2 / R3: pending value reads back but waits for the wrap
    wr(A_TOP, 8'd99);
    wr(A_MODE, 8'd2);
    wr(A_CMP0, 8'd40);
    wait_cnt(8'd99);
    wait_cnt(8'd10);
    wr(A_CMP0, 8'd80);
    rd(A_CMP0, d); chk("R2 pending readback", d, 8'd80);
    wait_cnt(8'd50);
    chk("R3 old compare still active", pwm_out[0], 1'b0);
    wait_cnt(8'd99);
    wait_cnt(8'd50);
    chk("R3 new compare after wrap", pwm_out[0], 1'b1);

    // R1 period length
    wait_cnt(8'd0);
    n = 0;
    do begin
      @(negedge clk); addr = A_CNT; #1; n++;
    end while (rdata != 8'd0);
    chk("R1 period clocks", n, 100);

    // R1 ceiling lowered below the running count
    wait_cnt(8'd80);
    wr(A_TOP, 8'd50);
    @(negedge clk);
    rd(A_CNT, d); chk("R1 wrap when count above ceiling", d, 8'd0);
    wr(A_TOP, 8'd99);

    // R9 / R10 / R11 flags
    wr(A_IEN, 8'd0);
    wait_cnt(8'd10);
    wr(A_FLAG, 8'h07);
    rd(A_FLAG, d); chk("R10 clear all flags", d, 8'h00);
    wait_cnt(8'd99);
    @(negedge clk);
    rd(A_FLAG, d); chk("R9 overflow flag set", d[0], 1'b1);
    chk("R11 overflow irq masked", irq_ovf, 1'b0);
    wr(A_IEN, 8'h01);
    chk("R11 overflow irq enabled", irq_ovf, 1'b1);
    chk("R11 compare irq masked", irq_cmp, 2'b00);
    wait_cnt(8'd81);
    rd(A_FLAG, d); chk("R9 compare flag set", d[1], 1'b1);
    wr(A_IEN, 8'h02);
    chk("R11 compare irq enabled", irq_cmp[0], 1'b1);
    chk("R11 overflow irq disabled", irq_ovf, 1'b0);
    wr(A_FLAG, 8'h01);
    rd(A_FLAG, d);
    chk("R10 targeted clear", d[0], 1'b0);
    chk("R10 other flag kept", d[1], 1'b1);
    wait_cnt(8'd99);
    wr_en = 1'b1; addr = A_FLAG; wdata = 8'h01;
    @(negedge clk);
    wr_en = 1'b0;
    rd(A_FLAG, d); chk("R10 set beats clear", d[0], 1'b1);

    // R7 / R3 both channels, companion pair on channel 1
    wr(A_MODE, 8'b0000_0110);
    wr(A_CMP0, 8'd20);
    wr(A_CMP1, 8'd60);
    wait_cnt(8'd99);
    wait_cnt(8'd40);
    chk("R3 channel 0 updated", pwm_out[0], 1'b0);
    chk("R7 channel 1 out", pwm_out[1], 1'b1);
    chk("R7 channel 1 out_n", pwm_out_n[1], 1'b0);
    chk("R7 channel 1 oe_n", pwm_oe_n[1], 1'b1);
    chk("R8 channel 0 companion off", {pwm_out_n[0], pwm_oe_n[0]}, 2'b00);

    // R12 reset mid-run
    rst_n = 1'b0;
    #1;
    chk("R12 pins in reset", {pwm_out, pwm_out_n, pwm_oe, pwm_oe_n}, 8'h00);
    rd(A_FLAG, d); chk("R12 flags in reset", d, 8'h00);
    rd(A_TOP, d);  chk("R12 ceiling in reset", d, 8'hFF);
    rd(A_CMP1, d); chk("R12 cmp1 in reset", d, 8'h00);
    rd(A_IEN, d);  chk("R12 enables in reset", d, 8'h00);

    summary();
    $finish;
  end

endmodule